// File: doc/BRIEF.md
# Line-Scan Camera Sync and Exposure Timing Generator

This block produces the three timing signals a line-scan camera needs: a camera clock, a sync pulse train and an exposure (integration) pulse. The camera clock comes from an integer divider of the system clock with a 50% duty cycle. Each sync period is a whole number of camera-clock cycles. Inside a period the sync pulse starts after a programmable delay and lasts for a programmable width. The exposure pulse is placed by a start offset and a stop offset, both measured from the first camera cycle of the period. Each output has its own polarity setting.

All period, pulse and exposure counters advance only on one chosen edge of the camera clock, either rising or falling. Every sync and exposure transition therefore lands in the same system-clock cycle as that camera-clock edge, which gives several cameras fed from the same block deterministic timing. The block can free-run, starting one period right after another. It can also wait for a trigger and run exactly one period per accepted trigger. The whole configuration is captured when a period begins, so reprogramming never cuts a running period short.

Top module: `cam_sync_gen`

## Requirements
- R1: While reset is asserted, `cam_clk`, `sync_out` and `exp_out` are low and `trig_miss_cnt` is zero.
- R2: `cam_clk` toggles every `cfg_half`+1 system clocks, so it is high for `cfg_half`+1 cycles and one camera cycle is 2*(`cfg_half`+1) system clocks.
- R3: In free-run mode (`cfg_trig_mode`=0), sync periods follow each other with no gap, and each lasts `cfg_period`+1 camera cycles.
- R4: The sync pulse becomes active `cfg_sync_dly` camera cycles after the period starts and stays active for `cfg_sync_wid` camera cycles. The exposure pulse therefore rises (`cfg_exp_start`-`cfg_sync_dly`) camera cycles after the sync pulse when start > delay.
- R5: The exposure pulse is active from camera-cycle offset `cfg_exp_start` (inclusive) to offset `cfg_exp_stop` (exclusive) within the period. If stop is not greater than start, no exposure pulse is produced.
- R6: A polarity bit of 1 makes its output active-high and 0 makes it active-low. When no period is running, each output rests at its inactive level.
- R7: Every transition of `sync_out` and `exp_out` happens in the same system-clock cycle as a `cam_clk` edge. That edge is rising when `cfg_edge_fall`=0 and falling when `cfg_edge_fall`=1.
- R8: Configuration changes made during a running period affect nothing until the next period begins. The running period keeps its programmed length.
- R9: In triggered mode (`cfg_trig_mode`=1), no period runs until `trig_in` is seen high on a clock edge. Each accepted trigger starts exactly one sync period, which begins on the next selected camera-clock edge.
- R10: In triggered mode, a trigger that arrives while a period is running or already pending is ignored, and `trig_miss_cnt` is incremented by one, saturating at all ones. In free-run mode, triggers are ignored and not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_half | input | DIV_W | Camera clock half period minus one, in system clocks |
| cfg_period | input | CNT_W | Sync period length minus one, in camera cycles |
| cfg_sync_dly | input | CNT_W | Sync pulse delay from period start, in camera cycles |
| cfg_sync_wid | input | CNT_W | Sync pulse width, in camera cycles |
| cfg_exp_start | input | CNT_W | Exposure start offset, in camera cycles |
| cfg_exp_stop | input | CNT_W | Exposure stop offset, in camera cycles |
| cfg_sync_pol | input | 1 | 1 = sync active-high, 0 = active-low |
| cfg_exp_pol | input | 1 | 1 = exposure active-high, 0 = active-low |
| cfg_edge_fall | input | 1 | 0 = align to rising camera-clock edge, 1 = falling |
| cfg_trig_mode | input | 1 | 0 = free-run, 1 = one period per trigger |
| trig_in | input | 1 | Trigger, sampled on each system clock edge |
| cam_clk | output | 1 | Divided camera clock |
| sync_out | output | 1 | External sync pulse |
| exp_out | output | 1 | Exposure control pulse |
| trig_miss_cnt | output | MISS_W | Saturating count of ignored triggers |

## Verification
The timing is exercised with four free-running setups: a fast clock aligned to the rising edge with active-high outputs, a slower clock aligned to the falling edge with active-low outputs, an exposure window whose stop equals its start, and a period length rewritten in the middle of a period. Together these separate the camera-clock divider, the period counter, the sync and exposure windows, the polarity handling and the choice of edge. They also show whether new settings leak into a running period. Triggered mode is tried with no trigger, one trigger, a second trigger inside the running period, and a trigger held high continuously. This distinguishes a single launch from repeated launches and shows that missed triggers are counted and that the counter saturates.

// File: rtl/cts_pkg.sv
package cts_pkg;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_e;
  typedef enum logic {RUN_FREE = 1'b0, RUN_TRIG = 1'b1} run_e;
endpackage

// File: rtl/cts_rst_sync.sv
module cts_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/cts_clk_div.sv
module cts_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half,
  output logic             cam_clk,
  output logic             tick_rise,
  output logic             tick_fall
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             clk_q, clk_d, wrap;

  // Next-state logic: toggle once the half period is used up.
  always_comb begin
    wrap      = (cnt_q >= half);
    cnt_d     = wrap ? '0 : cnt_q + DIV_W'(1);
    clk_d     = wrap ? ~clk_q : clk_q;
    tick_rise = wrap & ~clk_q;
    tick_fall = wrap &  clk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      clk_q <= clk_d;
    end
  end

  assign cam_clk = clk_q;
endmodule

// File: rtl/cts_trig_gate.sv
module cts_trig_gate #(
  parameter int MISS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_in,
  input  logic              trig_mode,
  input  logic              running,
  input  logic              accept,
  output logic              pend,
  output logic [MISS_W-1:0] miss_cnt
);
  import cts_pkg::*;

  logic              pend_q, pend_d, take, drop, miss_en;
  logic [MISS_W-1:0] miss_q, miss_d;

  always_comb begin
    take    = trig_in && (run_e'(trig_mode) == RUN_TRIG) && !running && !pend_q;
    drop    = trig_in && (run_e'(trig_mode) == RUN_TRIG) && (running || pend_q);
    pend_d  = accept ? 1'b0 : (take ? 1'b1 : pend_q);
    miss_en = drop && (miss_q != {MISS_W{1'b1}});
    miss_d  = miss_q + MISS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      miss_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (miss_en) miss_q <= miss_d;
    end
  end

  assign pend     = pend_q;
  assign miss_cnt = miss_q;
endmodule

// File: rtl/cts_period_seq.sv
module cts_period_seq #(
  parameter int CNT_W = 32,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_rise,
  input  logic             tick_fall,
  input  logic             pend,
  input  logic [DIV_W-1:0] cfg_half,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_sync_dly,
  input  logic [CNT_W-1:0] cfg_sync_wid,
  input  logic [CNT_W-1:0] cfg_exp_start,
  input  logic [CNT_W-1:0] cfg_exp_stop,
  input  logic             cfg_sync_pol,
  input  logic             cfg_exp_pol,
  input  logic             cfg_edge_fall,
  input  logic             cfg_trig_mode,
  output logic [DIV_W-1:0] half_sh,
  output logic             running,
  output logic             accept,
  output logic             sync_act,
  output logic             exp_act,
  output logic             sync_out,
  output logic             exp_out
);
  import cts_pkg::*;

  typedef struct packed {
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] dly;
    logic [CNT_W-1:0] wid;
    logic [CNT_W-1:0] start;
    logic [CNT_W-1:0] stop;
    logic [DIV_W-1:0] half;
    logic             spol;
    logic             epol;
    edge_e            edge_sel;
  } shadow_t;

  shadow_t          sh_q, sh_d, cfg_now;
  logic [CNT_W-1:0] pos_q, pos_d, pos_nx;
  logic             run_q, run_d, atk, free, at_end, start_go, wrap, halt;
  logic             load, pos_en, win_s, win_e;
  logic             sact_q, eact_q, sout_q, eout_q;

  always_comb begin
    cfg_now = '{period: cfg_period, dly: cfg_sync_dly, wid: cfg_sync_wid,
                start: cfg_exp_start, stop: cfg_exp_stop, half: cfg_half,
                spol: cfg_sync_pol, epol: cfg_exp_pol,
                edge_sel: edge_e'(cfg_edge_fall)};

    atk      = (sh_q.edge_sel == EDGE_FALL) ? tick_fall : tick_rise;
    free     = (run_e'(cfg_trig_mode) == RUN_FREE);
    at_end   = (pos_q == sh_q.period);
    start_go = !run_q && atk && (free || pend);
    wrap     = run_q && atk && at_end && free;
    halt     = run_q && atk && at_end && !free;
    run_d    = start_go || (run_q && !halt);

    // The configuration is captured only when a period begins.
    load     = !run_q || wrap;
    sh_d     = load ? cfg_now : sh_q;

    pos_en   = start_go || (run_q && atk && !halt);
    pos_d    = (start_go || wrap) ? '0 : pos_q + CNT_W'(1);
    pos_nx   = pos_en ? pos_d : pos_q;

    // Windows are evaluated on the post-edge position so that the
    // registered outputs switch together with the camera clock.
    win_s = run_d && (pos_nx >= sh_d.dly) &&
            ({1'b0, pos_nx} < ({1'b0, sh_d.dly} + {1'b0, sh_d.wid}));
    win_e = run_d && (pos_nx >= sh_d.start) && (pos_nx < sh_d.stop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      run_q  <= 1'b0;
      pos_q  <= '0;
      sact_q <= 1'b0;
      eact_q <= 1'b0;
      sout_q <= 1'b0;
      eout_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      run_q  <= run_d;
      if (pos_en) pos_q <= pos_d;
      sact_q <= win_s;
      eact_q <= win_e;
      sout_q <= sh_d.spol ? win_s : ~win_s;
      eout_q <= sh_d.epol ? win_e : ~win_e;
    end
  end

  assign half_sh  = sh_q.half;
  assign running  = run_q;
  assign accept   = start_go;
  assign sync_act = sact_q;
  assign exp_act  = eact_q;
  assign sync_out = sout_q;
  assign exp_out  = eout_q;
endmodule

// File: rtl/cam_sync_gen.sv
module cam_sync_gen #(
  parameter int CNT_W  = 32,
  parameter int DIV_W  = 8,
  parameter int MISS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_half,
  input  logic [CNT_W-1:0]  cfg_period,
  input  logic [CNT_W-1:0]  cfg_sync_dly,
  input  logic [CNT_W-1:0]  cfg_sync_wid,
  input  logic [CNT_W-1:0]  cfg_exp_start,
  input  logic [CNT_W-1:0]  cfg_exp_stop,
  input  logic              cfg_sync_pol,
  input  logic              cfg_exp_pol,
  input  logic              cfg_edge_fall,
  input  logic              cfg_trig_mode,
  input  logic              trig_in,
  output logic              cam_clk,
  output logic              sync_out,
  output logic              exp_out,
  output logic [MISS_W-1:0] trig_miss_cnt
);
  logic             rst_q_n;
  logic [DIV_W-1:0] half_sh;
  logic             tick_rise, tick_fall, pend, accept, run_act;
  logic             sync_act, exp_act;

  cts_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  cts_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .half      (half_sh),
    .cam_clk   (cam_clk),
    .tick_rise (tick_rise),
    .tick_fall (tick_fall)
  );

  cts_trig_gate #(.MISS_W(MISS_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .trig_in   (trig_in),
    .trig_mode (cfg_trig_mode),
    .running   (run_act),
    .accept    (accept),
    .pend      (pend),
    .miss_cnt  (trig_miss_cnt)
  );

  cts_period_seq #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_q_n),
    .tick_rise     (tick_rise),
    .tick_fall     (tick_fall),
    .pend          (pend),
    .cfg_half      (cfg_half),
    .cfg_period    (cfg_period),
    .cfg_sync_dly  (cfg_sync_dly),
    .cfg_sync_wid  (cfg_sync_wid),
    .cfg_exp_start (cfg_exp_start),
    .cfg_exp_stop  (cfg_exp_stop),
    .cfg_sync_pol  (cfg_sync_pol),
    .cfg_exp_pol   (cfg_exp_pol),
    .cfg_edge_fall (cfg_edge_fall),
    .cfg_trig_mode (cfg_trig_mode),
    .half_sh       (half_sh),
    .running       (run_act),
    .accept        (accept),
    .sync_act      (sync_act),
    .exp_act       (exp_act),
    .sync_out      (sync_out),
    .exp_out       (exp_out)
  );
endmodule

// File: rtl/cam_sync_gen_chk.sv
module cam_sync_gen_chk #(
  parameter int MISS_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cam_clk,
  input logic              sync_act,
  input logic              exp_act,
  input logic              running,
  input logic              trig_mode,
  input logic [MISS_W-1:0] miss_cnt
);
  // R7: sync window edges coincide with a camera clock edge
  a_r7_sync_on_cam_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_act != $past(sync_act)) |-> (cam_clk != $past(cam_clk)));

  // R7: exposure window edges coincide with a camera clock edge
  a_r7_exp_on_cam_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_act != $past(exp_act)) |-> (cam_clk != $past(cam_clk)));

  // R9: a period only begins on a camera clock edge
  a_r9_start_on_cam_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> (cam_clk != $past(cam_clk)));

  // R10: the miss counter only ever steps up by one
  a_r10_miss_step: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_cnt != $past(miss_cnt)) |-> (miss_cnt == $past(miss_cnt) + MISS_W'(1)));

  // R10: no triggers are counted in free-run mode
  a_r10_free_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_mode |=> $stable(miss_cnt));
endmodule

bind cam_sync_gen cam_sync_gen_chk #(.MISS_W(MISS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .cam_clk   (cam_clk),
  .sync_act  (sync_act),
  .exp_act   (exp_act),
  .running   (run_act),
  .trig_mode (cfg_trig_mode),
  .miss_cnt  (trig_miss_cnt)
);

// File: tb/cam_sync_gen_bench.sv
`timescale 1ns/1ps
module cam_sync_gen_bench;
  localparam int CNT_W  = 32;
  localparam int DIV_W  = 8;
  localparam int MISS_W = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [DIV_W-1:0]  cfg_half;
  logic [CNT_W-1:0]  cfg_period, cfg_sync_dly, cfg_sync_wid, cfg_exp_start, cfg_exp_stop;
  logic              cfg_sync_pol, cfg_exp_pol, cfg_edge_fall, cfg_trig_mode, trig_in;
  logic              cam_clk, sync_out, exp_out;
  logic [MISS_W-1:0] trig_miss_cnt;

  int checks = 0;
  int failures = 0;

  // scan results
  int sr0, sr1, sw, n_sr, er0, ew, n_er, cr0, cr1, cw, misalign, e_any, miss0;

  always #2.5 clk = ~clk;

  cam_sync_gen #(.CNT_W(CNT_W), .DIV_W(DIV_W), .MISS_W(MISS_W)) u_cam_sync_gen (
    .clk (clk), .rst_n (rst_n), .cfg_half (cfg_half), .cfg_period (cfg_period),
    .cfg_sync_dly (cfg_sync_dly), .cfg_sync_wid (cfg_sync_wid),
    .cfg_exp_start (cfg_exp_start), .cfg_exp_stop (cfg_exp_stop),
    .cfg_sync_pol (cfg_sync_pol), .cfg_exp_pol (cfg_exp_pol),
    .cfg_edge_fall (cfg_edge_fall), .cfg_trig_mode (cfg_trig_mode),
    .trig_in (trig_in), .cam_clk (cam_clk), .sync_out (sync_out),
    .exp_out (exp_out), .trig_miss_cnt (trig_miss_cnt)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int half, input int per, input int dly, input int wid,
                         input int est, input int esp, input bit spol, input bit epol,
                         input bit efall, input bit mode);
    cfg_half = DIV_W'(half); cfg_period = CNT_W'(per);
    cfg_sync_dly = CNT_W'(dly); cfg_sync_wid = CNT_W'(wid);
    cfg_exp_start = CNT_W'(est); cfg_exp_stop = CNT_W'(esp);
    cfg_sync_pol = spol; cfg_exp_pol = epol; cfg_edge_fall = efall; cfg_trig_mode = mode;
  endtask

  // Observe n cycles at the falling system edge; pulse trig_in at cycles t0/t1.
  task automatic scan(input int n, input int t0, input int t1);
    bit pc, ps, pe, c, s, e;
    sr0 = -1; sr1 = -1; sw = -1; n_sr = 0; er0 = -1; ew = -1; n_er = 0;
    cr0 = -1; cr1 = -1; cw = -1; misalign = 0; e_any = 0;
    miss0 = int'(trig_miss_cnt);
    pc = 0; ps = 0; pe = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      trig_in = (i == t0) || (i == t1);
      c = cam_clk;
      s = cfg_sync_pol ? sync_out : ~sync_out;
      e = cfg_exp_pol ? exp_out : ~exp_out;
      if (i > 0) begin
        if (c && !pc) begin
          if (cr0 < 0) cr0 = i; else if (cr1 < 0) cr1 = i;
        end
        if (!c && pc && cr0 >= 0 && cw < 0) cw = i - cr0;
        if ((s != ps) || (e != pe))
          if (!((c != pc) && (c == !cfg_edge_fall))) misalign++;
        if (s && !ps) begin
          n_sr++;
          if (sr0 < 0) sr0 = i; else if (sr1 < 0) sr1 = i;
        end
        if (!s && ps && sr0 >= 0 && sw < 0) sw = i - sr0;
        if (e && !pe) begin
          n_er++;
          if (sr0 >= 0 && er0 < 0) er0 = i;
        end
        if (!e && pe && er0 >= 0 && ew < 0) ew = i - er0;
      end
      if (e) e_any = 1;
      pc = c; ps = s; pe = e;
    end
    @(negedge clk);
    trig_in = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    trig_in = 1'b0;
    set_cfg(1, 9, 2, 3, 4, 7, 1, 1, 0, 0);
    repeat (5) @(negedge clk);
    check(cam_clk == 1'b0, "R1", "cam_clk in reset", cam_clk, 0);
    check(sync_out == 1'b0, "R1", "sync_out in reset", sync_out, 0);
    check(exp_out == 1'b0, "R1", "exp_out in reset", exp_out, 0);
    check(trig_miss_cnt == '0, "R1", "miss count in reset", trig_miss_cnt, 0);
    rst_n = 1'b1;
  endtask

  // Fast clock, rising edge, active-high; a free-run trigger is not counted.
  task automatic t_free_rise();
    set_cfg(1, 9, 2, 3, 4, 7, 1, 1, 0, 0);
    repeat (100) @(negedge clk);
    scan(200, 10, -1);
    check(cr1 - cr0 == 4, "R2", "camera period", cr1 - cr0, 4);
    check(cw == 2, "R2", "camera high time", cw, 2);
    check(sr1 - sr0 == 40, "R3", "sync period", sr1 - sr0, 40);
    check(sw == 12, "R4", "sync width", sw, 12);
    check(er0 - sr0 == 8, "R4", "exposure after sync", er0 - sr0, 8);
    check(ew == 12, "R5", "exposure width", ew, 12);
    check(misalign == 0, "R7", "transitions off rising edge", misalign, 0);
    check(int'(trig_miss_cnt) == miss0, "R10", "free-run trigger counted",
          trig_miss_cnt, miss0);
  endtask

  // Slower clock, falling edge, active-low outputs.
  task automatic t_free_fall_low();
    set_cfg(3, 9, 2, 3, 4, 7, 0, 0, 1, 0);
    repeat (200) @(negedge clk);
    scan(260, -1, -1);
    check(cr1 - cr0 == 8, "R2", "camera period half=3", cr1 - cr0, 8);
    check(cw == 4, "R2", "camera high time half=3", cw, 4);
    check(sr1 - sr0 == 80, "R3", "sync period slow clock", sr1 - sr0, 80);
    check(sw == 24, "R6", "active-low sync width", sw, 24);
    check(er0 - sr0 == 16, "R4", "exposure after sync slow", er0 - sr0, 16);
    check(ew == 24, "R6", "active-low exposure width", ew, 24);
    check(misalign == 0, "R7", "transitions off falling edge", misalign, 0);
  endtask

  task automatic t_exp_suppressed();
    set_cfg(1, 9, 2, 3, 5, 5, 1, 1, 0, 0);
    repeat (100) @(negedge clk);
    scan(150, -1, -1);
    check(e_any == 0, "R5", "exposure with stop==start", e_any, 0);
    check(n_sr >= 3, "R5", "sync still running", n_sr, 3);
  endtask

  // Period shortened in mid-period: current period keeps its length.
  task automatic t_update_boundary();
    bit ps, s;
    int t, t1, t2, guard;
    set_cfg(1, 9, 2, 3, 4, 7, 1, 1, 0, 0);
    repeat (100) @(negedge clk);
    ps = 1; guard = 0;
    do begin
      @(negedge clk); s = sync_out; guard++;
      if (s && !ps) break;
      ps = s;
    end while (guard < 200);
    cfg_period = CNT_W'(4);
    t = 0; t1 = -1; t2 = -1; ps = 1;
    while (t2 < 0 && t < 200) begin
      @(negedge clk); t++; s = sync_out;
      if (s && !ps) begin
        if (t1 < 0) t1 = t; else t2 = t;
      end
      ps = s;
    end
    check(t1 == 40, "R8", "period running at change", t1, 40);
    check(t2 - t1 == 20, "R8", "first period after change", t2 - t1, 20);
  endtask

  task automatic t_triggered();
    set_cfg(1, 9, 2, 3, 4, 7, 1, 1, 0, 1);
    repeat (200) @(negedge clk);
    scan(150, -1, -1);
    check(n_sr == 0, "R9", "sync pulses without trigger", n_sr, 0);
    check(sync_out == 1'b0, "R6", "idle sync level active-high", sync_out, 0);
    scan(150, 5, -1);
    check(n_sr == 1, "R9", "sync pulses for one trigger", n_sr, 1);
    check(int'(trig_miss_cnt) == miss0, "R9", "accepted trigger counted as miss",
          trig_miss_cnt, miss0);
    scan(150, 5, 20);
    check(n_sr == 1, "R10", "sync pulses with retrigger", n_sr, 1);
    check(int'(trig_miss_cnt) == miss0 + 1, "R10", "retrigger miss count",
          trig_miss_cnt, miss0 + 1);
    check(misalign == 0, "R7", "triggered transitions off edge", misalign, 0);
    cfg_sync_pol = 1'b0;
    cfg_exp_pol = 1'b0;
    repeat (10) @(negedge clk);
    check(sync_out == 1'b1, "R6", "idle sync level active-low", sync_out, 1);
    check(exp_out == 1'b1, "R6", "idle exposure level active-low", exp_out, 1);
  endtask

  task automatic t_miss_saturate();
    set_cfg(0, 1, 0, 1, 0, 1, 1, 1, 0, 1);
    repeat (20) @(negedge clk);
    trig_in = 1'b1;
    repeat (600) @(negedge clk);
    trig_in = 1'b0;
    repeat (5) @(negedge clk);
    check(trig_miss_cnt == {MISS_W{1'b1}}, "R10", "miss count saturation",
          trig_miss_cnt, (1 << MISS_W) - 1);
  endtask

  initial begin
    t_reset();
    t_free_rise();
    t_free_fall_low();
    t_exp_suppressed();
    t_update_boundary();
    t_triggered();
    t_miss_saturate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule